// File: doc/BRIEF.md
# ADC Scan-Complete Status Byte

This block is the byte-wide status and control register that sits beside a multi-channel A/D conversion sequencer and reports when a full scan has finished. The sequencer strobes the block every time a conversion result is stored, together with the index of the channel that was stored. When that index matches the configured final channel of the scan, a sticky scan-complete flag is raised.

The register also holds the enable bit for that flag. In continuous conversion mode, the flag and the enable together produce one of two requests. If DMA activation is off, the request is an interrupt. If DMA activation is on, the request goes to DMA instead. The enable bit also chooses which result storage the converter's overwrite protection guards. Software sees four status bits from a companion register mirrored into the upper nibble, so that one read returns the whole picture.

Software clears the flag by writing zero to it. When DMA is in use, a transfer-complete strobe also clears it. During read-modify-write cycles the flag reads back as one, so that a write-back of the value read cannot clear it by accident.

Top module: `adc_scan_status`

## Requirements
- R1: After reset, the enable bit (bit 0) and the flag (bit 1) are 0, and `eos_irq`, `dma_req` and `prot_sel` are low.
- R2: When `bus_rd` is high, `bus_rdata` returns the following. Bit 7 is `mir_busy`, bit 6 is `mir_int`, bit 5 is `mir_inte`, bit 4 is `mir_pause`, bits 3:2 are 0, bit 1 is the scan-complete flag and bit 0 is the enable. When `bus_rd` is low, `bus_rdata` is 0.
- R3: A write (`bus_wr`) loads bit 0 of `bus_wdata` into the enable. Bits 7:2 of `bus_wdata` have no effect on any state or output.
- R4: A store strobe whose channel index equals `last_ch` sets the flag on that clock edge. A store of any other channel leaves the flag unchanged.
- R5: A write with `bus_wdata[1]`=0 clears the flag. A write with `bus_wdata[1]`=1 leaves it unchanged.
- R6: `dma_done` clears the flag while `dma_en` is high. While `dma_en` is low, `dma_done` has no effect.
- R7: A set in the same cycle as a software clear or a DMA-done clear leaves the flag at 1.
- R8: `eos_irq` is high exactly while the flag, the enable and `cont_mode` are all 1 and `dma_en` is 0. It is a level that stays high as long as these conditions hold.
- R9: `dma_req` is high exactly while the flag, the enable, `cont_mode` and `dma_en` are all 1. `eos_irq` and `dma_req` are never high together.
- R10: With `cont_mode` low, neither `eos_irq` nor `dma_req` is raised, whatever the enable and the flag hold.
- R11: A read with `bus_rmw` high returns bit 1 as 1 whatever the flag holds, and does not change the flag.
- R12: `prot_sel` is 1 (guard the per-channel result array) when the enable and `cont_mode` are both 1. Otherwise it is 0 (guard the single result register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| store_valid | input | 1 | A result was stored this cycle |
| store_ch | input | CH_W | Channel index of the stored result |
| last_ch | input | CH_W | Configured final channel of the scan |
| cont_mode | input | 1 | Converter is in continuous mode |
| dma_en | input | 1 | DMA activation enabled |
| dma_done | input | 1 | DMA transfer complete strobe |
| mir_busy | input | 1 | Companion busy bit |
| mir_int | input | 1 | Companion conversion interrupt bit |
| mir_inte | input | 1 | Companion interrupt-enable bit |
| mir_pause | input | 1 | Companion pause bit |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rmw | input | 1 | Read is part of a read-modify-write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| eos_irq | output | 1 | Scan-complete interrupt request |
| dma_req | output | 1 | DMA activation request |
| prot_sel | output | 1 | Protection target: 1 = per-channel array, 0 = single register |

## Verification
The bench focuses on the collisions where a set arrives in the same cycle as a write-zero or a DMA-done clear. A design that gives priority to the clear would lose a finished scan. It writes ones to the mirrored and unused bit positions, which a design that latched them would then return on read. It performs read-modify-write reads while the flag is clear, and toggles `dma_en` and `cont_mode` while the flag is held. Getting these wrong would show up as three faults: a write-back that clears the flag, an interrupt and a DMA request raised together, or a request leaking out in single-shot modes. It also stores the channels just before and after the final one, and sends `dma_done` with DMA disabled, both of which must leave the flag alone.

// File: rtl/adc_scan_status.sv
module adc_scan_status #(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            store_valid,
  input  logic [CH_W-1:0] store_ch,
  input  logic [CH_W-1:0] last_ch,
  input  logic            cont_mode,
  input  logic            dma_en,
  input  logic            dma_done,
  input  logic            mir_busy,
  input  logic            mir_int,
  input  logic            mir_inte,
  input  logic            mir_pause,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic            bus_rmw,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  output logic            eos_irq,
  output logic            dma_req,
  output logic            prot_sel
);

  localparam int FLAG_BIT = 1;
  localparam int EN_BIT   = 0;

  logic eos_flag;
  logic eos_en;
  logic hit;
  logic sw_clr;
  logic dma_clr;
  logic armed;

  assign hit     = store_valid && (store_ch == last_ch);
  assign sw_clr  = bus_wr && !bus_wdata[FLAG_BIT];
  assign dma_clr = dma_en && dma_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eos_flag <= 1'b0;
    end else if (hit) begin
      eos_flag <= 1'b1;
    end else if (sw_clr || dma_clr) begin
      eos_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      eos_en <= 1'b0;
    else if (bus_wr)
      eos_en <= bus_wdata[EN_BIT];
  end

  assign armed    = eos_flag && eos_en && cont_mode;
  assign eos_irq  = armed && !dma_en;
  assign dma_req  = armed && dma_en;
  assign prot_sel = eos_en && cont_mode;

  assign bus_rdata = bus_rd
    ? {mir_busy, mir_int, mir_inte, mir_pause, 2'b00, eos_flag | bus_rmw, eos_en}
    : 8'h00;

  // R4: a matching store is visible as a set flag after the edge
  a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> eos_flag);

  // R4: the flag only rises after a matching store
  a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eos_flag) |-> $past(store_valid && store_ch == last_ch));

  // R5: software write of zero clears when no set competes
  a_r5_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_wdata[1] && !hit) |=> !eos_flag);

  // R6: DMA completion clears when DMA is in use and no set competes
  a_r6_dma_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && dma_done && !hit) |=> !eos_flag);

  // R9: interrupt and DMA request are exclusive
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eos_irq, dma_req}));

  // R10: no request outside continuous mode
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cont_mode |-> (!eos_irq && !dma_req));

  // R11: read-modify-write read leaves the flag as it was unless hardware acts
  a_r11_rmw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_rmw && !bus_wr && !hit && !dma_clr) |=> $stable(eos_flag));

endmodule

// File: tb/adc_scan_status_bench.sv
`timescale 1ns/1ps
module adc_scan_status_bench;
  localparam int CH_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic store_valid = 1'b0;
  logic [CH_W-1:0] store_ch = '0;
  logic [CH_W-1:0] last_ch = '0;
  logic cont_mode = 1'b0, dma_en = 1'b0, dma_done = 1'b0;
  logic mir_busy = 1'b0, mir_int = 1'b0, mir_inte = 1'b0, mir_pause = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_rmw = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic eos_irq, dma_req, prot_sel;

  always #2 clk = ~clk;

  adc_scan_status #(.CH_W(CH_W)) u_adc_scan_status (
    .clk(clk), .rst_n(rst_n), .store_valid(store_valid), .store_ch(store_ch),
    .last_ch(last_ch), .cont_mode(cont_mode), .dma_en(dma_en), .dma_done(dma_done),
    .mir_busy(mir_busy), .mir_int(mir_int), .mir_inte(mir_inte), .mir_pause(mir_pause),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rmw(bus_rmw), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .eos_irq(eos_irq), .dma_req(dma_req), .prot_sel(prot_sel)
  );

  typedef struct {
    logic [7:0] rdata;
    logic       irq;
    logic       dma;
    logic       prot;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic m_flag = 1'b0, m_en = 1'b0;
  logic [CH_W-1:0] t_last = '0;
  logic t_cont = 1'b0, t_dmaen = 1'b0, t_dmadone = 1'b0;
  logic [3:0] t_mir = 4'h0;

  task automatic cyc(input logic sv, input logic [CH_W-1:0] ch, input logic wr,
                     input logic [7:0] wd, input logic rd, input logic rmw,
                     input string tag);
    logic set, clr, nf, ne;
    exp_t e;
    @(negedge clk);
    store_valid = sv; store_ch = ch; bus_wr = wr; bus_wdata = wd;
    bus_rd = rd; bus_rmw = rmw; last_ch = t_last; cont_mode = t_cont;
    dma_en = t_dmaen; dma_done = t_dmadone;
    {mir_busy, mir_int, mir_inte, mir_pause} = t_mir;
    set = sv && (ch == t_last);
    clr = (wr && !wd[1]) || (t_dmadone && t_dmaen);
    nf = set ? 1'b1 : (clr ? 1'b0 : m_flag);
    ne = wr ? wd[0] : m_en;
    m_flag = nf; m_en = ne;
    e.rdata = rd ? {t_mir, 2'b00, nf | rmw, ne} : 8'h00;
    e.irq   = nf && ne && t_cont && !t_dmaen;
    e.dma   = nf && ne && t_cont && t_dmaen;
    e.prot  = ne && t_cont;
    e.tag   = tag;
    sb.push_back(e);
  endtask

  task automatic rd_only(input string tag);
    cyc(1'b0, '0, 1'b0, 8'h00, 1'b1, 1'b0, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (bus_rdata !== e.rdata || eos_irq !== e.irq || dma_req !== e.dma || prot_sel !== e.prot) begin
        errors++;
        $display("FAIL %s: got rdata=%h irq=%b dma=%b prot=%b, expected rdata=%h irq=%b dma=%b prot=%b",
                 e.tag, bus_rdata, eos_irq, dma_req, prot_sel, e.rdata, e.irq, e.dma, e.prot);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    bus_rd = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (bus_rdata !== 8'h00 || eos_irq !== 1'b0 || dma_req !== 1'b0 || prot_sel !== 1'b0) begin
      errors++;
      $display("FAIL R1: got rdata=%h irq=%b dma=%b prot=%b, expected 00 0 0 0",
               bus_rdata, eos_irq, dma_req, prot_sel);
    end
    @(negedge clk);
    rst_n = 1'b1;
    rd_only("R1");

    // R2: mirror layout
    t_mir = 4'b1010; rd_only("R2");
    t_mir = 4'b0101; rd_only("R2");
    cyc(1'b0, '0, 1'b0, 8'h00, 1'b0, 1'b0, "R2");

    // R3: upper bits ignored, bit 0 loads enable
    cyc(1'b0, '0, 1'b1, 8'hFE, 1'b1, 1'b0, "R3");
    cyc(1'b0, '0, 1'b1, 8'hFF, 1'b1, 1'b0, "R3");
    t_mir = 4'h0; rd_only("R3");

    // R4: only the final channel sets
    t_last = 5'd7;
    cyc(1'b1, 5'd6, 1'b0, 8'h00, 1'b1, 1'b0, "R4");
    cyc(1'b1, 5'd8, 1'b0, 8'h00, 1'b1, 1'b0, "R4");
    cyc(1'b1, 5'd7, 1'b0, 8'h00, 1'b1, 1'b0, "R4");

    // R5: write one keeps, write zero clears
    cyc(1'b0, '0, 1'b1, 8'h03, 1'b1, 1'b0, "R5");
    cyc(1'b0, '0, 1'b1, 8'h01, 1'b1, 1'b0, "R5");

    // R12: protection target
    t_cont = 1'b1; rd_only("R12");
    cyc(1'b0, '0, 1'b1, 8'h00, 1'b1, 1'b0, "R12");
    cyc(1'b0, '0, 1'b1, 8'h01, 1'b1, 1'b0, "R12");

    // R8: interrupt level
    cyc(1'b1, 5'd7, 1'b0, 8'h00, 1'b1, 1'b0, "R8");
    rd_only("R8"); rd_only("R8");

    // R10: no request outside continuous mode
    t_cont = 1'b0; rd_only("R10");
    t_dmaen = 1'b1; rd_only("R10");

    // R9: DMA request instead of interrupt
    t_cont = 1'b1; rd_only("R9");
    t_dmaen = 1'b0; rd_only("R9");
    t_dmaen = 1'b1; rd_only("R9");

    // R6: DMA done clears only with DMA enabled
    t_dmaen = 1'b0; t_dmadone = 1'b1; rd_only("R6");
    t_dmaen = 1'b1; rd_only("R6");
    t_dmadone = 1'b0; rd_only("R6");

    // R7: set wins over clears
    cyc(1'b1, 5'd7, 1'b1, 8'h01, 1'b1, 1'b0, "R7");
    cyc(1'b0, '0, 1'b1, 8'h01, 1'b1, 1'b0, "R7");
    t_dmadone = 1'b1;
    cyc(1'b1, 5'd7, 1'b0, 8'h00, 1'b1, 1'b0, "R7");
    t_dmadone = 1'b0; rd_only("R7");

    // R11: read-modify-write sees one, flag unchanged
    t_dmadone = 1'b1; rd_only("R11");
    t_dmadone = 1'b0;
    cyc(1'b0, '0, 1'b0, 8'h00, 1'b1, 1'b1, "R11");
    rd_only("R11");
    t_dmaen = 1'b0;
    cyc(1'b0, '0, 1'b0, 8'h00, 1'b1, 1'b1, "R11");
    rd_only("R11");

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule